// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is addressed to this station. The receive path hands it the six destination-address bytes as a stream, one byte per valid strobe, with a marker on the first byte. One clock after the sixth byte, the filter produces a single-cycle verdict that says accept or reject.

Individual (unicast) addresses are compared against a 48-bit station address that a host writes as two 32-bit words. Group addresses are hashed. A CRC-32 is run over the six bytes and part of the result selects one bit of a 64-bit table, which the host writes as two 32-bit halves. A promiscuous control input accepts everything. A broadcast-reject input drops frames sent to the all-ones address.

Top module: `dafilt_top`

## Requirements
- R1: The CRC register is preset to 0xFFFFFFFF on each first byte. Each byte is fed least-significant bit first. On every bit the register shifts left one place, and when the bit shifted out differs from the data bit it is XORed with 0x04C11DB7. No final inversion is applied.
- R2: The table bit position is CRC bits [5:1] with their order reversed: CRC bit 1 becomes position bit 4 and CRC bit 5 becomes position bit 0. This gives a position from 0 to 31.
- R3: CRC bit 0 picks the table half. A 1 looks up `hash_hi` and a 0 looks up `hash_lo`. A group frame is accepted exactly when the selected bit is 1.
- R4: A frame whose first byte has bit 0 set is a group frame and is judged only by the hash table, never by the station address. Any other frame is judged only by the station address, never by the table.
- R5: The station address is mapped as follows. Bytes 0 to 3 are `sta_hi[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Bytes 4 and 5 are `sta_lo[31:24]` and `[23:16]`. `sta_lo[15:0]` is unused. A unicast frame is accepted only when all six bytes match.
- R6: A frame whose six bytes are all 0xFF is broadcast. It is rejected when `bcast_rej` is 1 and accepted when `bcast_rej` is 0, whatever the table holds.
- R7: When `promisc` is 1, every verdict is accept. This overrides the broadcast reject and every address check.
- R8: `verdict_vld` pulses high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. It stays low at every other time.
- R9: A byte flagged `byte_first` always starts a new frame and discards any partial frame. Unflagged bytes that arrive before any first byte, or after the sixth byte, are ignored.
- R10: With both table halves all ones, every group frame is accepted.
- R11: After reset, `verdict_vld` and `verdict_acc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Address byte strobe |
| byte_first | input | 1 | Marks the first address byte of a frame |
| byte_data | input | 8 | Address byte |
| hash_hi | input | 32 | Group table half picked when CRC bit 0 is 1 |
| hash_lo | input | 32 | Group table half picked when CRC bit 0 is 0 |
| sta_hi | input | 32 | Station address bytes 0 to 3 |
| sta_lo | input | 32 | Station address bytes 4 and 5 in [31:16] |
| promisc | input | 1 | Accept every frame |
| bcast_rej | input | 1 | Reject all-ones destination |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_acc | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
Single-bit tables aim at the lookup. The bench first sets only the bit its model predicts, then only the mirror bit in the other half, then every bit except the predicted one. This separates a wrong bit reversal from a wrong half select. Unicast frames that differ from the station address in one byte at a time expose a wrong byte mapping. A group frame whose bytes equal the station address shows whether the two paths are kept apart. Broadcast is tried with each combination of promiscuous and reject, and truncated, restarted and overlong frames probe the framing. Random frames with random tables, control bits and strobe gaps then cover the CRC itself.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int HALF_W     = 32;
  localparam int IDX_W      = $clog2(HALF_W);
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  // Advance the CRC by one byte, least-significant bit first.
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[31] ^ d[k]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  // Table position: CRC bits [IDX_W:1] in reversed order.
  function automatic logic [IDX_W-1:0] hash_pos(input logic [31:0] c);
    logic [IDX_W-1:0] p;
    for (int k = 0; k < IDX_W; k++) p[IDX_W-1-k] = c[1+k];
    return p;
  endfunction
endpackage

// File: rtl/dafilt_crc.sv
module dafilt_crc
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base = first ? CRC_INIT : crc_q;
  assign crc_next = crc_byte(crc_base, data);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_INIT;
    else if (take) crc_q <= crc_next;
  end
endmodule

// File: rtl/dafilt_capture.sv
module dafilt_capture
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_first,
  input  logic [7:0]  byte_data,
  input  logic [31:0] sta_hi,
  input  logic [31:0] sta_lo,
  output logic        take,
  output logic        last_byte,
  output logic        grp_now,
  output logic        bc_now,
  output logic        st_now
);
  localparam int STA_W = 8 * ADDR_BYTES;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             grp_q, bc_q, st_q;
  logic [STA_W-1:0] sta_flat;
  logic [7:0]       sta_byte;
  logic             in_frame;

  assign sta_flat  = {sta_hi, sta_lo[31:16]};
  assign in_frame  = (cnt_q != '0) && (cnt_q < CNT_W'(ADDR_BYTES));
  assign take      = byte_vld && (byte_first || in_frame);
  assign pos       = byte_first ? '0 : cnt_q;
  assign last_byte = take && (pos == CNT_W'(ADDR_BYTES - 1));

  always_comb begin
    sta_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (pos == CNT_W'(i)) sta_byte = sta_flat[STA_W-1-8*i -: 8];
  end

  assign grp_now = byte_first ? byte_data[0] : grp_q;
  assign bc_now  = (byte_first ? 1'b1 : bc_q) && (byte_data == 8'hFF);
  assign st_now  = (byte_first ? 1'b1 : st_q) && (byte_data == sta_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      grp_q <= 1'b0;
      bc_q  <= 1'b0;
      st_q  <= 1'b0;
    end else if (take) begin
      cnt_q <= pos + 1'b1;
      grp_q <= grp_now;
      bc_q  <= bc_now;
      st_q  <= st_now;
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));
  assert_first_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_first) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide
  import dafilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last_byte,
  input  logic [31:0]       crc,
  input  logic              grp,
  input  logic              bc,
  input  logic              st,
  input  logic [HALF_W-1:0] hash_hi,
  input  logic [HALF_W-1:0] hash_lo,
  input  logic              promisc,
  input  logic              bcast_rej,
  output logic              verdict_vld,
  output logic              verdict_acc
);
  logic [IDX_W-1:0]  hpos;
  logic [HALF_W-1:0] half;
  logic              hash_hit;
  logic              acc_now;

  assign hpos     = hash_pos(crc);
  assign half     = crc[0] ? hash_hi : hash_lo;
  assign hash_hit = half[hpos];

  always_comb begin
    if (promisc)  acc_now = 1'b1;
    else if (bc)  acc_now = !bcast_rej;
    else if (grp) acc_now = hash_hit;
    else          acc_now = st;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      verdict_vld <= 1'b0;
      verdict_acc <= 1'b0;
    end else begin
      verdict_vld <= last_byte;
      verdict_acc <= last_byte && acc_now;
    end
  end

  assert_promisc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(promisc)) |-> verdict_acc);
  assert_bcast_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(bc && bcast_rej && !promisc)) |-> !verdict_acc);
  assert_acc_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_acc |-> verdict_vld);
endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_first,
  input  logic [7:0]  byte_data,
  input  logic [31:0] hash_hi,
  input  logic [31:0] hash_lo,
  input  logic [31:0] sta_hi,
  input  logic [31:0] sta_lo,
  input  logic        promisc,
  input  logic        bcast_rej,
  output logic        verdict_vld,
  output logic        verdict_acc
);
  logic        take, last_byte, grp_now, bc_now, st_now;
  logic [31:0] crc_next;

  dafilt_capture u_cap (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_first(byte_first),
    .byte_data(byte_data), .sta_hi(sta_hi), .sta_lo(sta_lo), .take(take),
    .last_byte(last_byte), .grp_now(grp_now), .bc_now(bc_now), .st_now(st_now)
  );

  dafilt_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(byte_first),
    .data(byte_data), .crc_next(crc_next)
  );

  dafilt_decide u_dec (
    .clk(clk), .rst_n(rst_n), .last_byte(last_byte), .crc(crc_next),
    .grp(grp_now), .bc(bc_now), .st(st_now), .hash_hi(hash_hi),
    .hash_lo(hash_lo), .promisc(promisc), .bcast_rej(bcast_rej),
    .verdict_vld(verdict_vld), .verdict_acc(verdict_acc)
  );

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);
  assert_verdict_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> $past(take));
endmodule

// File: tb/sim_dafilt_top.sv
module sim_dafilt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0, byte_first = 1'b0;
  logic [7:0] byte_data = '0;
  logic [31:0] hash_hi = '0, hash_lo = '0, sta_hi = '0, sta_lo = '0;
  logic promisc = 1'b0, bcast_rej = 1'b0;
  logic verdict_vld, verdict_acc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dafilt_top u0 (.*);

  typedef logic [7:0] mac_t [6];

  // Bench model: treat the address as a 48-bit serial stream.
  function automatic logic [31:0] m_crc(mac_t a);
    logic [47:0] s;
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) s[8*i +: 8] = a[i];
    for (int k = 0; k < 48; k++) begin
      logic fb = c[31] ^ s[k];
      c = (c << 1) ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  function automatic int m_pos(logic [31:0] c);
    int p = 0;
    for (int j = 0; j < 5; j++) if (c[1+j]) p += (1 << (4 - j));
    return p;
  endfunction

  function automatic bit m_accept(mac_t a);
    logic [31:0] c = m_crc(a);
    bit bc = 1'b1, st;
    logic [47:0] sa = {sta_hi, sta_lo[31:16]};
    st = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (a[i] != 8'hFF) bc = 1'b0;
      if (a[i] != sa[47-8*i -: 8]) st = 1'b0;
    end
    if (promisc) return 1'b1;
    if (bc) return !bcast_rej;
    if (a[0][0]) return c[0] ? hash_hi[m_pos(c)] : hash_lo[m_pos(c)];
    return st;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] d, bit f);
    @(negedge clk);
    byte_vld = 1'b1; byte_first = f; byte_data = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b0; byte_first = 1'b0;
      chk(verdict_vld == 1'b0, "R8 idle", verdict_vld, 0);
    end
  endtask

  // Send a frame; check the pulse in the cycle after the sixth byte.
  task automatic frame(mac_t a, int gap, string req, bit exp);
    for (int i = 0; i < 6; i++) begin
      put(a[i], i == 0);
      if (gap > 0 && i < 5) begin
        @(negedge clk);
        byte_vld = 1'b0; byte_first = 1'b0;
        chk(verdict_vld == 1'b0, "R8 gap", verdict_vld, 0);
      end
    end
    @(negedge clk);
    byte_vld = 1'b0; byte_first = 1'b0;
    chk(verdict_vld == 1'b1, "R8 pulse", verdict_vld, 1);
    chk(verdict_acc == exp, req, verdict_acc, exp);
    @(negedge clk);
    chk(verdict_vld == 1'b0, "R8 single", verdict_vld, 0);
  endtask

  function automatic mac_t rnd_mac();
    mac_t a;
    for (int i = 0; i < 6; i++) a[i] = 8'($urandom);
    return a;
  endfunction

  initial begin : main
    mac_t a, g, bc;
    logic [31:0] c;
    int p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(verdict_vld == 1'b0 && verdict_acc == 1'b0, "R11 reset", {verdict_vld, verdict_acc}, 0);
    rst_n = 1'b1;
    idle(2);
    // Unflagged bytes before any first byte: ignored (R9)
    for (int i = 0; i < 8; i++) put(8'h10 + 8'(i), 1'b0);
    idle(2);

    sta_hi = 32'h0250_C2A1; sta_lo = 32'h7E93_5A5A;
    a[0]=8'h02; a[1]=8'h50; a[2]=8'hC2; a[3]=8'hA1; a[4]=8'h7E; a[5]=8'h93;
    frame(a, 0, "R5 station match", 1'b1);
    for (int b = 0; b < 6; b++) begin
      mac_t m = a;
      m[b] = m[b] ^ 8'h40;
      frame(m, b % 2, "R5 one byte differs", 1'b0);
    end
    hash_hi = '1; hash_lo = '1;
    a[5] = 8'h94;
    frame(a, 0, "R4 unicast ignores table", 1'b0);
    a[5] = 8'h93;

    // Group frame equal to station address: table only (R4)
    sta_hi = 32'h0350_C2A1;
    g = a; g[0] = 8'h03;
    hash_hi = '0; hash_lo = '0;
    frame(g, 0, "R4 group ignores station", 1'b0);
    hash_hi = '1; hash_lo = '1;
    frame(g, 1, "R10 all-ones table", 1'b1);

    // Single-bit table probes (R1 R2 R3)
    g[0]=8'h01; g[1]=8'h00; g[2]=8'h5E; g[3]=8'h00; g[4]=8'h00; g[5]=8'hFB;
    c = m_crc(g); p = m_pos(c);
    hash_hi = '0; hash_lo = '0;
    if (c[0]) hash_hi[p] = 1'b1; else hash_lo[p] = 1'b1;
    frame(g, 0, "R2 predicted bit", 1'b1);
    hash_hi = '0; hash_lo = '0;
    if (c[0]) hash_lo[p] = 1'b1; else hash_hi[p] = 1'b1;
    frame(g, 0, "R3 other half", 1'b0);
    hash_hi = '1; hash_lo = '1;
    if (c[0]) hash_hi[p] = 1'b0; else hash_lo[p] = 1'b0;
    frame(g, 0, "R2 all but predicted", 1'b0);

    // Broadcast (R6, R7)
    for (int i = 0; i < 6; i++) bc[i] = 8'hFF;
    hash_hi = '0; hash_lo = '0;
    bcast_rej = 1'b0; frame(bc, 0, "R6 broadcast accepted", 1'b1);
    bcast_rej = 1'b1; hash_hi = '1; hash_lo = '1;
    frame(bc, 0, "R6 broadcast rejected", 1'b0);
    promisc = 1'b1; frame(bc, 1, "R7 promisc over reject", 1'b1);
    a[0] = 8'h44; frame(a, 0, "R7 promisc unicast", 1'b1);
    promisc = 1'b0;

    // Restart mid-frame and overlong frame (R9)
    sta_hi = 32'h0250_C2A1; a[0] = 8'h02;
    put(8'h77, 1'b1); put(8'h66, 1'b0); put(8'h55, 1'b0);
    frame(a, 0, "R9 restart", 1'b1);
    for (int i = 0; i < 6; i++) put(a[i], i == 0);
    put(8'hEE, 1'b0);
    chk(verdict_vld && verdict_acc, "R9 seventh byte timing", {verdict_vld, verdict_acc}, 2'b11);
    @(negedge clk); byte_vld = 1'b0;
    chk(verdict_vld == 1'b0, "R9 seventh byte ignored", verdict_vld, 0);
    idle(2);

    // Random frames (R1 through R7)
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 7);
      hash_hi = $urandom; hash_lo = $urandom;
      promisc = ($urandom_range(0, 7) == 0);
      bcast_rej = $urandom_range(0, 1);
      a = rnd_mac();
      if (sel == 0) a = bc;
      if (sel == 1) begin
        a[0] = 8'h02; a[1] = 8'h50; a[2] = 8'hC2; a[3] = 8'hA1; a[4] = 8'h7E; a[5] = 8'h93;
      end
      if (sel >= 4) a[0][0] = 1'b1;
      frame(a, $urandom_range(0, 1), "R1 random frame", m_accept(a));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule